// File: doc/BRIEF.md
# Two-Level Environment Configuration Register Pair

This block keeps two 64-bit environment configuration registers for a processor core. One belongs to the machine level and the other to the hypervisor level. A single CSR-style port reaches both registers. The port has a two-bit register selector, a write strobe, write data and combinational read data. A mode input picks 64-bit or 32-bit operation. In 32-bit mode each register is split into a low word and a high word, and the selector chooses between them.

The low byte holds the cache-block control fields, and these are always writable. The three top bits are optional controls:
- bit 61 enables hardware accessed/dirty updates;
- bit 62 enables page-based memory types;
- bit 63 enables the supervisor timer compare.

In the machine register, each optional bit can be written only when its static feature-enable input says the feature exists. The hypervisor register holds copies of the same three bits, and the machine register gates them. A copy accepts a write only while its machine bit is 1, and it reads as zero while that machine bit is 0. The stored copy is kept while gated, so it reappears when the machine bit is set again.

Top module: `env_cfg_pair`

## Requirements
- R1: After reset both registers hold zero, so every selector reads zero.
- R2: Bits 7:4 of both registers are always writable: a two-bit invalidate control at 5:4, the clean/flush enable at bit 6 and the zero enable at bit 7. Every bit other than 7:4 and 63:61 reads zero and ignores writes.
- R3: Machine bit 61 (feature input featAdUpd), bit 62 (featMemType) and bit 63 (featTimeCmp) take a written value only when their feature input is 1 at the write. Otherwise the bit keeps its value, which is zero when the feature input is held low.
- R4: Each write updates only the bits inside its mask, and all other bits keep their previous value. For example, a high-word write leaves bits 7:4 unchanged.
- R5: A write to hypervisor bit 61, 62 or 63 takes effect only if the matching machine bit is 1 at that clock edge. Otherwise the stored hypervisor bit is unchanged.
- R6: A hypervisor read returns each of bits 63:61 ANDed with the matching machine bit. The stored hypervisor bit survives a clear of the machine bit and reads as 1 again once the machine bit is set.
- R7: Selector encoding: 0 = machine, 1 = machine high word, 2 = hypervisor, 3 = hypervisor high word. In 32-bit mode (xlen64 = 0):
  - selectors 0 and 2 read bits 31:0 zero-extended, and writes to them affect only bits 31:0;
  - selectors 1 and 3 return bits 63:32 on rdata[31:0] with the upper half zero, and writes to them place wdata[31:0] into bits 63:32.
- R8: In 64-bit mode (xlen64 = 1), selectors 0 and 2 give full-width access. Selectors 1 and 3 read zero, and writes to them are ignored.
- R9: Read data follows the selector in the same cycle. A write becomes visible only after the next rising clock edge, so during the write cycle the old value is still read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xlen64 | input | 1 | 1 = 64-bit access, 0 = 32-bit split access |
| csrSel | input | 2 | Register/word selector |
| csrWe | input | 1 | Write strobe |
| csrWdata | input | 64 | Write data |
| featAdUpd | input | 1 | Hardware A/D-update feature present |
| featMemType | input | 1 | Page-based memory type feature present |
| featTimeCmp | input | 1 | Supervisor timer compare feature present |
| csrRdata | output | 64 | Read data for the selected register or word |

## Verification
Reads are combinational, so a read result is due in the same cycle the selector is applied. The bench sets the selector just after a falling edge and samples one time unit later, before the next rising edge. A write is due at the first rising edge after the strobe. The bench raises the strobe at a falling edge, lets one rising edge pass, and clears the strobe at the following falling edge. It then reads back all four selectors within that low phase and compares each one with a reference model updated at the same edge. One directed check samples the read data while the write strobe is still high, to confirm the old value is returned until the edge.

// File: rtl/env_cfg_pkg.sv
package env_cfg_pkg;
  localparam int REG_W    = 64;
  localparam int HALF_W   = REG_W / 2;
  localparam int NUM_OPT  = 3;
  localparam int OPT_LSB  = REG_W - NUM_OPT;
  localparam int SEL_W    = 2;

  localparam logic [REG_W-1:0] LOW_FIELDS = REG_W'(8'hF0);
  localparam logic [REG_W-1:0] OPT_FIELDS = {{NUM_OPT{1'b1}}, {OPT_LSB{1'b0}}};
  localparam logic [REG_W-1:0] HI_WORD    = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
  localparam logic [REG_W-1:0] LO_WORD    = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  localparam logic [SEL_W-1:0] SEL_MACH    = 2'd0;
  localparam logic [SEL_W-1:0] SEL_MACH_HI = 2'd1;
  localparam logic [SEL_W-1:0] SEL_HYP     = 2'd2;
  localparam logic [SEL_W-1:0] SEL_HYP_HI  = 2'd3;

  typedef struct packed {
    logic machWr;
    logic hypWr;
    logic readHyp;
    logic hiWord;
    logic loWord;
    logic nullSel;
  } cfg_strobe_t;
endpackage

// File: rtl/env_cfg_ctrl.sv
module env_cfg_ctrl
  import env_cfg_pkg::*;
(
  input  logic             xlen64,
  input  logic [SEL_W-1:0] csrSel,
  input  logic             csrWe,
  output cfg_strobe_t      ctl
);
  logic isHiSel;
  logic isHypSel;

  assign isHiSel  = csrSel[0];
  assign isHypSel = csrSel[1];

  always_comb begin
    ctl = '0;
    ctl.readHyp = isHypSel;
    ctl.nullSel = xlen64 && isHiSel;
    ctl.hiWord  = !xlen64 && isHiSel;
    ctl.loWord  = !xlen64 && !isHiSel;
    ctl.machWr  = csrWe && !isHypSel && !ctl.nullSel;
    ctl.hypWr   = csrWe && isHypSel && !ctl.nullSel;
  end
endmodule

// File: rtl/env_cfg_dp.sv
module env_cfg_dp
  import env_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfg_strobe_t        ctl,
  input  logic [REG_W-1:0]   csrWdata,
  input  logic [NUM_OPT-1:0] featBits,
  output logic [REG_W-1:0]   csrRdata
);
  logic [REG_W-1:0] machReg, hypReg;
  logic [REG_W-1:0] wordMask, machMask, hypMask, wdPlaced;
  logic [REG_W-1:0] featField, viewVal;

  assign featField = {featBits, {OPT_LSB{1'b0}}};

  always_comb begin
    if (ctl.hiWord) begin
      wordMask = HI_WORD;
      wdPlaced = {csrWdata[HALF_W-1:0], {HALF_W{1'b0}}};
    end else if (ctl.loWord) begin
      wordMask = LO_WORD;
      wdPlaced = csrWdata;
    end else begin
      wordMask = '1;
      wdPlaced = csrWdata;
    end
  end

  assign machMask = (LOW_FIELDS | featField) & wordMask;
  assign hypMask  = (LOW_FIELDS | (machReg & OPT_FIELDS)) & wordMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      machReg <= '0;
      hypReg  <= '0;
    end else begin
      if (ctl.machWr) machReg <= (machReg & ~machMask) | (wdPlaced & machMask);
      if (ctl.hypWr)  hypReg  <= (hypReg & ~hypMask) | (wdPlaced & hypMask);
    end
  end

  assign viewVal = ctl.readHyp ? (hypReg & (~OPT_FIELDS | machReg)) : machReg;

  always_comb begin
    if (ctl.nullSel)     csrRdata = '0;
    else if (ctl.hiWord) csrRdata = {{HALF_W{1'b0}}, viewVal[REG_W-1:HALF_W]};
    else if (ctl.loWord) csrRdata = {{HALF_W{1'b0}}, viewVal[HALF_W-1:0]};
    else                 csrRdata = viewVal;
  end

  // R2: bits outside the defined fields never hold a one
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((machReg | hypReg) & ~(LOW_FIELDS | OPT_FIELDS)) == '0);

  // R4: without a write strobe a register holds its value
  p_hold_mach_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.machWr) |-> machReg == $past(machReg));
  p_hold_hyp_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.hypWr) |-> hypReg == $past(hypReg));

  for (genvar i = 0; i < NUM_OPT; i++) begin : g_optChk
    // R3: a machine optional bit changes only if its feature was present
    p_feat_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
      (machReg[OPT_LSB+i] != $past(machReg[OPT_LSB+i])) |-> $past(featBits[i]));
    // R5: a hypervisor optional bit changes only while the machine bit was set
    p_hyp_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
      (hypReg[OPT_LSB+i] != $past(hypReg[OPT_LSB+i])) |-> $past(machReg[OPT_LSB+i]));
    // R6: a full-width hypervisor read never shows a gated bit
    p_read_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.readHyp && !ctl.nullSel && !ctl.hiWord && !ctl.loWord && !machReg[OPT_LSB+i])
        |-> !csrRdata[OPT_LSB+i]);
  end
endmodule

// File: rtl/env_cfg_pair.sv
module env_cfg_pair
  import env_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             xlen64,
  input  logic [SEL_W-1:0] csrSel,
  input  logic             csrWe,
  input  logic [REG_W-1:0] csrWdata,
  input  logic             featAdUpd,
  input  logic             featMemType,
  input  logic             featTimeCmp,
  output logic [REG_W-1:0] csrRdata
);
  cfg_strobe_t ctl;

  env_cfg_ctrl u_ctrl (
    .xlen64 (xlen64),
    .csrSel (csrSel),
    .csrWe  (csrWe),
    .ctl    (ctl)
  );

  env_cfg_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .csrWdata (csrWdata),
    .featBits ({featTimeCmp, featMemType, featAdUpd}),
    .csrRdata (csrRdata)
  );
endmodule

// File: tb/env_cfg_pair_tb_top.sv
module env_cfg_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] LOWF = 64'h0000_0000_0000_00F0;
  localparam logic [63:0] OPTF = 64'hE000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xlen64 = 1'b1;
  logic [1:0] csrSel = '0;
  logic csrWe = 1'b0;
  logic [63:0] csrWdata = '0;
  logic featAdUpd = 1'b0, featMemType = 1'b0, featTimeCmp = 1'b0;
  logic [63:0] csrRdata;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [63:0] mM = '0, mH = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  env_cfg_pair dut_i (
    .clk(clk), .rstN(rstN), .xlen64(xlen64), .csrSel(csrSel), .csrWe(csrWe),
    .csrWdata(csrWdata), .featAdUpd(featAdUpd), .featMemType(featMemType),
    .featTimeCmp(featTimeCmp), .csrRdata(csrRdata)
  );

  function automatic logic [63:0] feats();
    return {featTimeCmp, featMemType, featAdUpd, 61'b0};
  endfunction

  // expected read value per R6, R7, R8
  function automatic logic [63:0] expRead(logic [1:0] s, logic m64);
    logic [63:0] v;
    v = s[1] ? (mH & (~OPTF | mM)) : mM;
    if (m64) return s[0] ? 64'h0 : v;
    return s[0] ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [1:0] s, logic m64, logic [63:0] d);
    logic [63:0] wm, wd, mk;
    @(negedge clk);
    xlen64 = m64; csrSel = s; csrWdata = d; csrWe = 1'b1;
    if (m64) begin wm = s[0] ? 64'h0 : '1; wd = d; end
    else if (s[0]) begin wm = {32'hFFFF_FFFF, 32'h0}; wd = {d[31:0], 32'h0}; end
    else begin wm = {32'h0, 32'hFFFF_FFFF}; wd = d; end
    if (!s[1]) begin
      mk = (LOWF | feats()) & wm;
      mM = (mM & ~mk) | (wd & mk);
    end else begin
      mk = (LOWF | (mM & OPTF)) & wm;
      mH = (mH & ~mk) | (wd & mk);
    end
    @(posedge clk);
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic checkAll(string tag, logic m64);
    for (int s = 0; s < 4; s++) begin
      xlen64 = m64; csrSel = 2'(s);
      #1;
      check(tag, csrRdata, expRead(2'(s), m64));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1", 1'b1);                       // R1 reset state
    checkAll("R1", 1'b0);

    // R2: low fields writable, everything else stuck at zero
    doWrite(2'd0, 1'b1, '1); checkAll("R2", 1'b1);
    check("R2", csrRdata, 64'h0);
    xlen64 = 1'b1; csrSel = 2'd0; #1;
    check("R2", csrRdata, 64'h0000_0000_0000_00F0);

    // R3: feature off keeps machine bits zero
    featAdUpd = 1'b1;
    doWrite(2'd0, 1'b1, '1);
    xlen64 = 1'b1; csrSel = 2'd0; #1;
    check("R3", csrRdata, 64'h2000_0000_0000_00F0);

    // R9: during the write cycle the old value is still read
    @(negedge clk);
    xlen64 = 1'b1; csrSel = 2'd0; csrWdata = 64'h0; csrWe = 1'b1; #1;
    check("R9", csrRdata, 64'h2000_0000_0000_00F0);
    mM = 64'h0;
    @(posedge clk); #1;
    check("R9", csrRdata, 64'h0);
    @(negedge clk); csrWe = 1'b0;

    // R8: high selectors ignored in 64-bit mode
    featMemType = 1'b1; featTimeCmp = 1'b1;
    doWrite(2'd1, 1'b1, '1); checkAll("R8", 1'b1);

    // R7 and R4: high-word write in 32-bit mode keeps the low fields
    doWrite(2'd0, 1'b0, 64'hA0); doWrite(2'd1, 1'b0, 64'hFFFF_FFFF);
    checkAll("R7", 1'b0); checkAll("R4", 1'b1);

    // R5, R6: exhaustive feature x machine-bit combinations
    for (int f = 0; f < 8; f++) begin
      for (int m = 0; m < 8; m++) begin
        featAdUpd = f[0]; featMemType = f[1]; featTimeCmp = f[2];
        doWrite(2'd0, 1'b1, {3'(m), 61'h50});
        doWrite(2'd2, 1'b1, (m[0] ? '1 : 64'h0) ^ {3'(f), 61'h0});
        checkAll("R5", 1'b1); checkAll("R6", 1'b0);
      end
    end

    // R6: stored hypervisor bits survive a gating period
    featAdUpd = 1'b1; featMemType = 1'b1; featTimeCmp = 1'b1;
    doWrite(2'd0, 1'b1, OPTF); doWrite(2'd2, 1'b1, OPTF);
    doWrite(2'd0, 1'b1, 64'h0); checkAll("R6", 1'b1);
    doWrite(2'd0, 1'b1, OPTF); checkAll("R6", 1'b1);
    xlen64 = 1'b1; csrSel = 2'd2; #1;
    check("R6", csrRdata & OPTF, OPTF);

    // random mix covering R3 R4 R5 R7 R8
    for (int n = 0; n < 400; n++) begin
      logic [2:0] fr;
      fr = 3'($urandom);
      featAdUpd = fr[0]; featMemType = fr[1]; featTimeCmp = fr[2];
      doWrite(2'($urandom), 1'($urandom), {$urandom, $urandom});
      checkAll("R4", 1'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule